// File: doc/BRIEF.md
# Configuration completion receiver

This block sits on the receive side of a root port and waits for the completion of one outstanding configuration request. The request side arms it with a one-cycle pulse that carries the direction (read or write), the access size and the two low address bits. The block then watches a stream of 64-bit completion beats, each marked with start and end flags. From the start beat it takes the three-bit completion status. When the end beat arrives it returns a result to the request side.

A read that completes cleanly returns the lower 32-bit word of the end beat, shifted and masked to the requested byte lanes. A write completes under the same pass/fail rule and returns no data. If no end beat arrives within a fixed budget of clock cycles, the request fails. The result is one done pulse carrying a two-bit result code and a 32-bit data word.

Top module: `cfg_cpl_rx`

## Requirements
- R1: An arm pulse while idle raises busy on the next cycle and latches direction, size and address bits. An arm pulse while busy is ignored, and the running request keeps its own settings.
- R2: Only beats with rx_valid high are considered, so an end flag with rx_valid low does not finish a request. Once a start has been taken, beats without flags are accepted but do not change the captured status.
- R3: The completion status is rx_data[47:45] (bits 15:13 of the upper word) of the start beat. When start and end arrive on the same beat, that beat's status is the one used.
- R4: Each request begins with a nonzero held status, so an end beat taken before any start beat fails with code 1.
- R5: On the end beat, status zero gives result code 0 (success). Any nonzero status gives code 1 (device not found) with done_data zero.
- R6: Read data alignment depends on req_size. Size 0 (byte) returns the lower word shifted right by 8*addr[1:0] and masked to 0xFF. Size 1 (halfword) returns it shifted right by 16*addr[1] and masked to 0xFFFF. Sizes 2 and 3 (word) return it unchanged.
- R7: A completed write returns done_data zero whatever the beat carried.
- R8: With LIMIT = CLK_MHZ*POLL_US*POLL_COUNT, a request with no end beat ends with code 1 and data zero, with done high exactly LIMIT cycles after the cycle in which busy first reads high. The counter restarts on every accepted arm.
- R9: done is high for one cycle only, and busy is low whenever done is high. Result code 2 (bad register) is reserved and never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | One-cycle request start |
| req_is_read | input | 1 | 1 for a read, 0 for a write |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_addr_lo | input | 2 | Low two bits of the register address |
| rx_valid | input | 1 | A receive beat is present |
| rx_sop | input | 1 | Beat starts a completion |
| rx_eop | input | 1 | Beat ends a completion |
| rx_data | input | 64 | Beat payload, upper word holds the status |
| busy | output | 1 | A request is outstanding |
| done | output | 1 | One-cycle result strobe |
| done_status | output | 2 | 0 success, 1 device not found, 2 bad register |
| done_data | output | 32 | Aligned read data, zero otherwise |

## Verification
The bench builds the block with CLK_MHZ=1, POLL_US=1 and POLL_COUNT=40, which gives a 40-cycle wait budget. With that budget the bench can measure the exact cycle of the timeout pulse. It can also show that a later request, kept idle for most of the budget, still succeeds because the counter restarted. The default budget of 250000 cycles would push every timeout case past the bench's run length.

// File: rtl/cfg_cpl_pkg.sv
package cfg_cpl_pkg;

  typedef enum logic [1:0] {
    RES_OK       = 2'd0,
    RES_NODEV    = 2'd1,
    RES_BADREG   = 2'd2,
    RES_RSVD     = 2'd3
  } cpl_res_e;

  localparam int unsigned BEAT_W   = 64;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned STAT_W   = 3;
  localparam int unsigned STAT_LSB = 45;

  // Lane alignment of returned read data.
  function automatic logic [WORD_W-1:0] lane_align(
    input logic [WORD_W-1:0] dw,
    input logic [1:0]        sz,
    input logic [1:0]        lo
  );
    logic [WORD_W-1:0] r;
    case (sz)
      2'd0:    r = (dw >> {lo, 3'b000}) & 32'h0000_00FF;
      2'd1:    r = (dw >> {lo[1], 4'b0000}) & 32'h0000_FFFF;
      default: r = dw;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cpl_beat_track.sv
module cpl_beat_track
  import cfg_cpl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_acc,
  input  logic              busy,
  input  logic              rx_valid,
  input  logic              rx_sop,
  input  logic              rx_eop,
  input  logic [BEAT_W-1:0] rx_data,
  output logic              take_beat,
  output logic              end_hit,
  output logic [STAT_W-1:0] eff_stat,
  output logic              sop_seen
);
  logic [STAT_W-1:0] stat_q;
  logic [STAT_W-1:0] beat_stat;

  assign beat_stat = rx_data[STAT_LSB +: STAT_W];
  assign take_beat = busy && rx_valid && (rx_sop || rx_eop || sop_seen);
  assign end_hit   = take_beat && rx_eop;
  assign eff_stat  = rx_sop ? beat_stat : stat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sop_seen <= 1'b0;
      stat_q   <= '1;
    end else if (arm_acc) begin
      sop_seen <= 1'b0;
      stat_q   <= '1;
    end else if (take_beat && rx_sop) begin
      sop_seen <= 1'b1;
      stat_q   <= beat_stat;
    end
  end
endmodule

// File: rtl/cpl_wait_timer.sv
module cpl_wait_timer #(
  parameter int unsigned LIMIT = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic expire
);
  localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  assign expire = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (clear)  cnt <= '0;
    else if (run)    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cpl_lane_align.sv
module cpl_lane_align
  import cfg_cpl_pkg::*;
(
  input  logic [WORD_W-1:0] dw,
  input  logic [1:0]        size,
  input  logic [1:0]        addr_lo,
  output logic [WORD_W-1:0] aligned
);
  assign aligned = lane_align(dw, size, addr_lo);
endmodule

// File: rtl/cfg_cpl_rx.sv
module cfg_cpl_rx
  import cfg_cpl_pkg::*;
#(
  parameter int unsigned CLK_MHZ    = 100,
  parameter int unsigned POLL_US    = 5,
  parameter int unsigned POLL_COUNT = 500
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        arm,
  input  logic        req_is_read,
  input  logic [1:0]  req_size,
  input  logic [1:0]  req_addr_lo,
  input  logic        rx_valid,
  input  logic        rx_sop,
  input  logic        rx_eop,
  input  logic [63:0] rx_data,
  output logic        busy,
  output logic        done,
  output logic [1:0]  done_status,
  output logic [31:0] done_data
);
  localparam int unsigned LIMIT = CLK_MHZ * POLL_US * POLL_COUNT;

  logic              busy_q;
  logic              is_read_q;
  logic [1:0]        size_q;
  logic [1:0]        lo_q;
  logic              arm_acc;
  logic              take_beat;
  logic              end_hit;
  logic [STAT_W-1:0] eff_stat;
  logic              sop_seen_w;
  logic              expire;
  logic              finish_eop;
  logic              timeout_hit;
  logic              finish;
  logic              cpl_good;
  logic [WORD_W-1:0] aligned;

  assign arm_acc     = arm && !busy_q;
  assign finish_eop  = end_hit;
  assign timeout_hit = expire && !end_hit;
  assign finish      = finish_eop || timeout_hit;
  assign cpl_good    = finish_eop && (eff_stat == '0);

  cpl_beat_track u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm_acc   (arm_acc),
    .busy      (busy_q),
    .rx_valid  (rx_valid),
    .rx_sop    (rx_sop),
    .rx_eop    (rx_eop),
    .rx_data   (rx_data),
    .take_beat (take_beat),
    .end_hit   (end_hit),
    .eff_stat  (eff_stat),
    .sop_seen  (sop_seen_w)
  );

  cpl_wait_timer #(.LIMIT(LIMIT)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (arm_acc),
    .run    (busy_q),
    .expire (expire)
  );

  cpl_lane_align u_align (
    .dw      (rx_data[WORD_W-1:0]),
    .size    (size_q),
    .addr_lo (lo_q),
    .aligned (aligned)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      is_read_q <= 1'b0;
      size_q    <= 2'd0;
      lo_q      <= 2'd0;
    end else if (arm_acc) begin
      busy_q    <= 1'b1;
      is_read_q <= req_is_read;
      size_q    <= req_size;
      lo_q      <= req_addr_lo;
    end else if (finish) begin
      busy_q    <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done        <= 1'b0;
      done_status <= RES_OK;
      done_data   <= '0;
    end else begin
      done        <= finish;
      if (finish) begin
        done_status <= cpl_good ? RES_OK : RES_NODEV;
        done_data   <= (cpl_good && is_read_q) ? aligned : '0;
      end
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/cfg_cpl_rx_chk.sv
module cfg_cpl_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        arm,
  input logic        busy,
  input logic        done,
  input logic [1:0]  done_status,
  input logic [31:0] done_data,
  input logic        rx_valid,
  input logic        rx_sop,
  input logic        rx_eop,
  input logic        sop_seen,
  input logic        is_read_q,
  input logic        timeout_hit
);
  p_arm_starts_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && !busy) |=> busy);

  p_quiet_no_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rx_valid && !timeout_hit) |=> !done);

  p_orphan_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rx_valid && rx_eop && !rx_sop && !sop_seen) |=> (done && done_status == 2'd1));

  p_fail_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_status != 2'd0) |-> (done_data == 32'd0));

  p_write_no_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !is_read_q) |-> (done_data == 32'd0));

  p_timeout_fails_r8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_hit |=> (done && done_status == 2'd1 && done_data == 32'd0));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_no_badreg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (done_status != 2'd2));
endmodule

bind cfg_cpl_rx cfg_cpl_rx_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .arm         (arm),
  .busy        (busy),
  .done        (done),
  .done_status (done_status),
  .done_data   (done_data),
  .rx_valid    (rx_valid),
  .rx_sop      (rx_sop),
  .rx_eop      (rx_eop),
  .sop_seen    (sop_seen_w),
  .is_read_q   (is_read_q),
  .timeout_hit (timeout_hit)
);

// File: tb/sim_cfg_cpl_rx.sv
module sim_cfg_cpl_rx;
  localparam int unsigned LIM = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arm = 1'b0;
  logic        req_is_read = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [1:0]  req_addr_lo = 2'd0;
  logic        rx_valid = 1'b0;
  logic        rx_sop = 1'b0;
  logic        rx_eop = 1'b0;
  logic [63:0] rx_data = '0;
  logic        busy;
  logic        done;
  logic [1:0]  done_status;
  logic [31:0] done_data;

  typedef struct {
    logic [1:0]  st;
    logic [31:0] dat;
    int          lat;
    int          t0;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;
  int   arm_cyc = 0;
  logic prev_done = 1'b0;

  cfg_cpl_rx #(.CLK_MHZ(1), .POLL_US(1), .POLL_COUNT(LIM)) u0 (
    .clk(clk), .rst_n(rst_n), .arm(arm), .req_is_read(req_is_read),
    .req_size(req_size), .req_addr_lo(req_addr_lo), .rx_valid(rx_valid),
    .rx_sop(rx_sop), .rx_eop(rx_eop), .rx_data(rx_data), .busy(busy),
    .done(done), .done_status(done_status), .done_data(done_data)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input logic ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic push_exp(input logic [1:0] st, input logic [31:0] d, input int lat, input string tag);
    exp_t e;
    e.st = st; e.dat = d; e.lat = lat; e.t0 = arm_cyc; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic arm_req(input logic rd, input logic [1:0] sz, input logic [1:0] lo);
    @(negedge clk);
    arm = 1'b1; req_is_read = rd; req_size = sz; req_addr_lo = lo;
    @(negedge clk);
    arm = 1'b0;
    arm_cyc = cyc;
  endtask

  task automatic beat(input logic v, input logic s, input logic e, input logic [63:0] d);
    @(negedge clk);
    rx_valid = v; rx_sop = s; rx_eop = e; rx_data = d;
    @(negedge clk);
    rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Monitor: pops expected results as done pulses appear.
  initial begin
    forever begin
      @(negedge clk);
      if (done && prev_done) check(1'b0, "R9 done longer than one cycle", 1, 0);
      if (done) begin
        check(!busy, "R9 busy low with done", busy, 0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R1 unexpected done", done_status, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(done_status == e.st, {e.tag, " status"}, done_status, e.st);
          check(done_data == e.dat, {e.tag, " data"}, done_data, e.dat);
          if (e.lat != 0)
            check((cyc - e.t0) == e.lat, {e.tag, " latency"}, cyc - e.t0, e.lat);
        end
      end
      prev_done = done;
    end
  end

  initial begin
    repeat (300000) @(posedge clk);
    check(1'b0, "watchdog expired", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    check(!done && !busy, "R9 reset idle", {done, busy}, 0);

    // R1 arm raises busy; word read success (R5, R6 word)
    arm_req(1'b1, 2'd2, 2'd0);
    check(busy, "R1 busy after arm", busy, 1);
    beat(1'b1, 1'b1, 1'b0, 64'h0000_0FFF_0000_0000);
    push_exp(2'd0, 32'hDEAD_BEEF, 0, "R5 word read ok");
    beat(1'b1, 1'b0, 1'b1, 64'h0000_0000_DEAD_BEEF);
    idle(2);

    // R1 arm while busy ignored; R6 byte at lane 2
    arm_req(1'b1, 2'd0, 2'd2);
    arm_req(1'b1, 2'd2, 2'd0);
    check(busy, "R1 still busy", busy, 1);
    beat(1'b1, 1'b1, 1'b0, 64'h0000_0000_0000_0000);
    push_exp(2'd0, 32'h0000_00B2, 0, "R1 R6 byte lane2");
    beat(1'b1, 1'b0, 1'b1, 64'h0000_0000_A1B2_C3D4);
    idle(2);

    // R6 halfword at addr 2 and addr 1
    arm_req(1'b1, 2'd1, 2'd2);
    beat(1'b1, 1'b1, 1'b0, 64'h0);
    push_exp(2'd0, 32'h0000_A1B2, 0, "R6 half addr2");
    beat(1'b1, 1'b0, 1'b1, 64'h0000_0000_A1B2_C3D4);
    idle(2);
    arm_req(1'b1, 2'd1, 2'd1);
    beat(1'b1, 1'b1, 1'b0, 64'h0);
    push_exp(2'd0, 32'h0000_C3D4, 0, "R6 half addr1");
    beat(1'b1, 1'b0, 1'b1, 64'h0000_0000_A1B2_C3D4);
    idle(2);

    // R3 start and end on same beat, byte at lane 3
    arm_req(1'b1, 2'd0, 2'd3);
    push_exp(2'd0, 32'h0000_0011, 0, "R3 single beat ok");
    beat(1'b1, 1'b1, 1'b1, 64'h0000_1FFF_1122_3344);
    idle(2);

    // R5 nonzero status on start beat -> not found
    arm_req(1'b1, 2'd2, 2'd0);
    beat(1'b1, 1'b1, 1'b0, 64'h0000_8000_0000_0000);
    push_exp(2'd1, 32'h0, 0, "R5 bad status");
    beat(1'b1, 1'b0, 1'b1, 64'h0000_0000_1234_5678);
    idle(2);

    // R3 single beat with status 1 -> not found
    arm_req(1'b1, 2'd2, 2'd0);
    push_exp(2'd1, 32'h0, 0, "R3 single beat status");
    beat(1'b1, 1'b1, 1'b1, 64'h0000_2000_1234_5678);
    idle(2);

    // R4 end beat without start -> not found
    arm_req(1'b1, 2'd2, 2'd0);
    push_exp(2'd1, 32'h0, 0, "R4 end without start");
    beat(1'b1, 1'b0, 1'b1, 64'h0000_0000_CAFE_F00D);
    idle(2);

    // R2 end with valid low ignored; flagless beat after start keeps status
    arm_req(1'b1, 2'd2, 2'd0);
    beat(1'b0, 1'b0, 1'b1, 64'h0000_0000_0BAD_0BAD);
    check(busy, "R2 invalid end ignored", busy, 1);
    beat(1'b1, 1'b1, 1'b0, 64'h0);
    beat(1'b1, 1'b0, 1'b0, 64'h0000_E000_0000_0000);
    push_exp(2'd0, 32'h7777_8888, 0, "R2 middle beat");
    beat(1'b1, 1'b0, 1'b1, 64'h0000_0000_7777_8888);
    idle(2);

    // R7 write success returns zero data
    arm_req(1'b0, 2'd2, 2'd0);
    beat(1'b1, 1'b1, 1'b0, 64'h0);
    push_exp(2'd0, 32'h0, 0, "R7 write ok");
    beat(1'b1, 1'b0, 1'b1, 64'h0000_0000_5555_5555);
    idle(2);

    // R8 timeout at exact latency
    arm_req(1'b1, 2'd2, 2'd0);
    push_exp(2'd1, 32'h0, LIM, "R8 timeout");
    idle(LIM + 4);
    check(!busy, "R8 idle after timeout", busy, 0);

    // R8 counter restarts on arm: long wait then success
    arm_req(1'b1, 2'd2, 2'd0);
    idle(LIM - 12);
    beat(1'b1, 1'b1, 1'b0, 64'h0);
    push_exp(2'd0, 32'h0101_0202, 0, "R8 restart ok");
    beat(1'b1, 1'b0, 1'b1, 64'h0000_0000_0101_0202);
    idle(4);

    check(exp_q.size() == 0, "R9 all results seen", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule